// File: doc/BRIEF.md
# Page-Mode Parallel Flash Read Controller

This block sits between a synchronous host and an asynchronous parallel NOR flash that offers a page read mode. The host hands over one read request at a time: an address and a byte/word mode flag. The controller drives chip enable, output enable, the byte-mode pin, the lane-select pin and the word address. It then waits a number of clock cycles that depends on how the new address relates to the previous one, samples the data bus and returns the value with a one-cycle valid strobe.

The controller records the last word address, lane and mode, and whether the device is currently selected. A new page, a mode change or a freshly selected device takes a long wait. A different word or byte inside the open page takes the short in-page wait. Re-reading exactly the same location takes a minimal wait, because the device keeps that output latched even after it drops into its automatic sleep. When no request is accepted for a set number of cycles, the controller deselects the device to save power. The next read then pays the full selection delay, which also covers the power-up rule that a read must follow a chip-enable transition.

Top module: `flashrd_top`

## Requirements
- R1: While reset is held and right after it, flashCeN, flashOeN and flashByteN are high, reqReady is high and rspValid is low.
- R2: A request is accepted on a rising edge where reqValid and reqReady are both high, and the pins change on that edge. In word mode (reqByteMode=0), flashAddr = reqAddr[ADDR_W-1:0], flashLane = 0 and flashByteN = 1, and reqAddr[ADDR_W] is ignored. In byte mode, flashAddr = reqAddr[ADDR_W:1], flashLane = reqAddr[0] and flashByteN = 0. These pins then hold until the next acceptance.
- R3: If the device is deselected when a request is accepted (after reset or standby), chip enable goes low on the accepting edge and rspValid rises max(RAND_WAIT, CE_WAIT) edges after the accepting edge.
- R4: With the device selected, a request whose page tag (word address bits ADDR_W-1 down to log2(PAGE_WORDS)) differs from the previous one, or whose mode differs from the previous one, gets rspValid RAND_WAIT edges after acceptance.
- R5: With the device selected and the same mode and tag, a request to a different word or lane gets rspValid PAGE_WAIT edges after acceptance.
- R6: With the device selected, a request to exactly the previous word, lane and mode gets rspValid REREAD_WAIT edges after acceptance.
- R7: rspValid is high for exactly one cycle per accepted request. reqReady is low from the accepting edge until the edge that raises rspValid. rspData is the sampled bus in word mode, and in byte mode it is bus bits 7:0 with the upper bits zero.
- R8: After IDLE_LIMIT consecutive rising edges with reqReady high, the device selected and no acceptance, flashCeN and flashOeN go high on the last of those edges.
- R9: An acceptance on the edge where standby would otherwise begin takes priority. Chip enable stays low, and the request is classified as if the device were still selected.
- R10: flashOeN equals flashCeN at all times, and the bus is sampled only while both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Read request present |
| reqReady | output | 1 | Controller can accept a request |
| reqAddr | input | ADDR_W+1 | Request address; in byte mode the LSB selects the lane |
| reqByteMode | input | 1 | 1 for byte access, 0 for word access |
| rspValid | output | 1 | One-cycle strobe for returned data |
| rspData | output | DATA_W | Returned read data |
| flashCeN | output | 1 | Flash chip enable, active low |
| flashOeN | output | 1 | Flash output enable, active low |
| flashByteN | output | 1 | Flash byte-mode select, low for byte mode |
| flashLane | output | 1 | Byte-lane address bit below the word address |
| flashAddr | output | ADDR_W | Flash word address |
| flashData | input | DATA_W | Flash data bus |

## Verification
Two functions can collide on one edge: the idle timer reaching its limit, and the acceptance of a new request. Directed reads are spaced so that the request lands exactly on the expiry edge, and again one edge later. The bench reference model predicts a short in-page wait with chip enable still low in the first case, and a full selection wait after a visible chip-enable rise in the second. The random phase mixes gaps that straddle the limit with same-word, same-page, new-page and mode-flip addresses, so the collision also comes up unplanned.

// File: rtl/flashrd_pkg.sv
package flashrd_pkg;

  typedef enum logic [1:0] {
    PATH_FULL,
    PATH_RAND,
    PATH_PAGE,
    PATH_SAME
  } accPath_t;

  typedef enum logic [0:0] {
    ST_IDLE,
    ST_WAIT
  } ctrlState_t;

  typedef struct packed {
    logic loadReq;
    logic capture;
    logic standby;
  } dpStrobe_t;

endpackage

// File: rtl/flashrd_dp.sv
module flashrd_dp
  import flashrd_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int PAGE_WORDS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         st,
  input  logic [ADDR_W:0]   reqAddr,
  input  logic              reqByteMode,
  input  logic [DATA_W-1:0] flashData,
  output accPath_t          path,
  output logic              sessionOpen,
  output logic              flashCeN,
  output logic              flashOeN,
  output logic              flashByteN,
  output logic              flashLane,
  output logic [ADDR_W-1:0] flashAddr,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);

  localparam int OFF_W = $clog2(PAGE_WORDS);

  logic [ADDR_W-1:0] addrQ;
  logic              laneQ;
  logic              modeQ;
  logic              openQ;   // device selected and stored page tag valid
  logic              rspValidQ;
  logic [DATA_W-1:0] rspDataQ;

  logic [ADDR_W-1:0] reqWord;
  logic              reqLane;
  logic              tagHit;
  logic [DATA_W-1:0] busSel;

  assign reqWord = reqByteMode ? reqAddr[ADDR_W:1] : reqAddr[ADDR_W-1:0];
  assign reqLane = reqByteMode & reqAddr[0];
  assign tagHit  = (reqWord[ADDR_W-1:OFF_W] == addrQ[ADDR_W-1:OFF_W]);

  always_comb begin
    if (!openQ)                            path = PATH_FULL;
    else if (!tagHit || modeQ != reqByteMode) path = PATH_RAND;
    else if (reqWord == addrQ && reqLane == laneQ) path = PATH_SAME;
    else                                   path = PATH_PAGE;
  end

  generate
    if (DATA_W > 8) begin : g_wide
      assign busSel = modeQ ? {{(DATA_W-8){1'b0}}, flashData[7:0]} : flashData;
    end else begin : g_narrow
      assign busSel = flashData;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ     <= '0;
      laneQ     <= 1'b0;
      modeQ     <= 1'b0;
      openQ     <= 1'b0;
      rspValidQ <= 1'b0;
      rspDataQ  <= '0;
    end else begin
      if (st.loadReq) begin
        addrQ <= reqWord;
        laneQ <= reqLane;
        modeQ <= reqByteMode;
        openQ <= 1'b1;
      end else if (st.standby) begin
        openQ <= 1'b0;
      end
      rspValidQ <= st.capture;
      if (st.capture) rspDataQ <= busSel;
    end
  end

  assign sessionOpen = openQ;
  assign flashCeN    = !openQ;
  assign flashOeN    = !openQ;
  assign flashByteN  = !modeQ;
  assign flashLane   = laneQ;
  assign flashAddr   = addrQ;
  assign rspValid    = rspValidQ;
  assign rspData     = rspDataQ;

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R7
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !st.loadReq |=> $stable(flashAddr)); // R2
  AST_CAPTURE_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    st.capture |-> (!flashCeN && !flashOeN)); // R10
  AST_STANDBY_SLOW: assert property (@(posedge clk) disable iff (!rstN)
    st.standby |=> (path == PATH_FULL && flashCeN)); // R8

endmodule

// File: rtl/flashrd_ctrl.sv
module flashrd_ctrl
  import flashrd_pkg::*;
#(
  parameter int RAND_WAIT   = 14,
  parameter int PAGE_WAIT   = 5,
  parameter int CE_WAIT     = 16,
  parameter int REREAD_WAIT = 1,
  parameter int IDLE_LIMIT  = 40
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  output logic      reqReady,
  input  accPath_t  path,
  input  logic      sessionOpen,
  output dpStrobe_t st
);

  localparam int FULL_WAIT = (RAND_WAIT > CE_WAIT) ? RAND_WAIT : CE_WAIT;
  localparam int CNT_W     = $clog2(FULL_WAIT + 1);
  localparam int IDLE_W    = $clog2(IDLE_LIMIT + 1);

  ctrlState_t        state;
  logic [CNT_W-1:0]  waitCnt;
  logic [IDLE_W-1:0] idleCnt;
  logic [CNT_W-1:0]  waitSel;
  logic              accept;
  logic              lastWait;

  always_comb begin
    case (path)
      PATH_FULL: waitSel = CNT_W'(FULL_WAIT);
      PATH_RAND: waitSel = CNT_W'(RAND_WAIT);
      PATH_PAGE: waitSel = CNT_W'(PAGE_WAIT);
      default:   waitSel = CNT_W'(REREAD_WAIT);
    endcase
  end

  assign reqReady   = (state == ST_IDLE);
  assign accept     = reqValid && reqReady;
  assign lastWait   = (state == ST_WAIT) && (waitCnt == CNT_W'(1));
  assign st.loadReq = accept;
  assign st.capture = lastWait;
  assign st.standby = reqReady && !accept && sessionOpen &&
                      (idleCnt == IDLE_W'(IDLE_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      idleCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_WAIT;
            waitCnt <= waitSel;
            idleCnt <= '0;
          end else if (sessionOpen) begin
            idleCnt <= st.standby ? '0 : idleCnt + 1'b1;
          end
        end
        default: begin
          if (lastWait) begin
            state   <= ST_IDLE;
            idleCnt <= '0;
          end else begin
            waitCnt <= waitCnt - 1'b1;
          end
        end
      endcase
    end
  end

  AST_READY_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqReady) |-> $past(st.capture)); // R7
  AST_WAIT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) |-> (waitCnt != '0 && waitCnt <= CNT_W'(FULL_WAIT))); // R3
  AST_OPEN_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> sessionOpen); // R9

endmodule

// File: rtl/flashrd_top.sv
module flashrd_top
  import flashrd_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 16,
  parameter int PAGE_WORDS  = 8,
  parameter int RAND_WAIT   = 14,
  parameter int PAGE_WAIT   = 5,
  parameter int CE_WAIT     = 16,
  parameter int REREAD_WAIT = 1,
  parameter int IDLE_LIMIT  = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W:0]   reqAddr,
  input  logic              reqByteMode,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              flashCeN,
  output logic              flashOeN,
  output logic              flashByteN,
  output logic              flashLane,
  output logic [ADDR_W-1:0] flashAddr,
  input  logic [DATA_W-1:0] flashData
);

  dpStrobe_t st;
  accPath_t  path;
  logic      sessionOpen;

  flashrd_ctrl #(
    .RAND_WAIT(RAND_WAIT), .PAGE_WAIT(PAGE_WAIT), .CE_WAIT(CE_WAIT),
    .REREAD_WAIT(REREAD_WAIT), .IDLE_LIMIT(IDLE_LIMIT)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .path(path), .sessionOpen(sessionOpen), .st(st)
  );

  flashrd_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_WORDS(PAGE_WORDS)
  ) i_dp (
    .clk(clk), .rstN(rstN), .st(st), .reqAddr(reqAddr),
    .reqByteMode(reqByteMode), .flashData(flashData), .path(path),
    .sessionOpen(sessionOpen), .flashCeN(flashCeN), .flashOeN(flashOeN),
    .flashByteN(flashByteN), .flashLane(flashLane), .flashAddr(flashAddr),
    .rspValid(rspValid), .rspData(rspData)
  );

endmodule

// File: tb/test_flashrd_top.sv
module test_flashrd_top;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int AW = 20;
  localparam int DW = 16;
  localparam int RW = 14;
  localparam int PW = 5;
  localparam int CW = 16;
  localparam int SW = 1;
  localparam int IL = 40;
  localparam int FW = (RW > CW) ? RW : CW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [AW:0]   reqAddr = '0;
  logic          reqByteMode = 1'b0;
  logic          rspValid;
  logic [DW-1:0] rspData;
  logic          flashCeN, flashOeN, flashByteN, flashLane;
  logic [AW-1:0] flashAddr;
  logic [DW-1:0] busVal;
  wire  [DW-1:0] flashData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  flashrd_top #(
    .ADDR_W(AW), .DATA_W(DW), .PAGE_WORDS(8), .RAND_WAIT(RW), .PAGE_WAIT(PW),
    .CE_WAIT(CW), .REREAD_WAIT(SW), .IDLE_LIMIT(IL)
  ) i_flashrd_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqByteMode(reqByteMode), .rspValid(rspValid),
    .rspData(rspData), .flashCeN(flashCeN), .flashOeN(flashOeN),
    .flashByteN(flashByteN), .flashLane(flashLane), .flashAddr(flashAddr),
    .flashData(flashData)
  );

  function automatic logic [15:0] cellVal(input logic [AW-1:0] a);
    return a[15:0] ^ {a[19:16], a[19:8]} ^ 16'h3C5A;
  endfunction

  function automatic logic [15:0] expData(input logic [AW-1:0] w, input logic lane,
                                          input logic mode);
    logic [15:0] c;
    c = cellVal(w);
    if (!mode) return c;
    return {8'h00, lane ? c[15:8] : c[7:0]};
  endfunction

  // flash model: upper byte carries junk in byte mode
  always_comb begin
    if (flashByteN) busVal = cellVal(flashAddr);
    else busVal = {8'hA5, flashLane ? cellVal(flashAddr)[15:8] : cellVal(flashAddr)[7:0]};
  end
  assign flashData = (!flashCeN && !flashOeN) ? busVal : 'z;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model, updated at each falling edge for the preceding rising edge
  bit            sV = 1'b0, sR = 1'b0, sMode = 1'b0;
  logic [AW:0]   sAddr = '0;
  bit            mOpen = 1'b0, mMode = 1'b0, mLane = 1'b0, mPending = 1'b0;
  logic [AW-1:0] mWord = '0;
  int            mIdle = 0, mCyc = 0, mExpWait = 0;
  logic [15:0]   mExpData = '0;
  string         mTag = "R3";

  always @(negedge clk) begin
    if (rstN) begin
      if (mPending) mCyc++;
      if (sV && sR) begin
        logic [AW-1:0] w;
        logic ln;
        w  = sMode ? sAddr[AW:1] : sAddr[AW-1:0];
        ln = sMode & sAddr[0];
        if (!mOpen) begin mExpWait = FW; mTag = "R3"; end
        else if (w[AW-1:3] != mWord[AW-1:3] || sMode != mMode) begin
          mExpWait = RW; mTag = (mIdle == IL-1) ? "R9" : "R4";
        end else if (w == mWord && ln == mLane) begin
          mExpWait = SW; mTag = (mIdle == IL-1) ? "R9" : "R6";
        end else begin
          mExpWait = PW; mTag = (mIdle == IL-1) ? "R9" : "R5";
        end
        mOpen = 1'b1; mWord = w; mLane = ln; mMode = sMode;
        mIdle = 0; mPending = 1'b1; mCyc = 0;
        mExpData = expData(w, ln, sMode);
      end else if (sR && mOpen) begin
        mIdle++;
        if (mIdle == IL) begin mOpen = 1'b0; mIdle = 0; end
      end
      if (rspValid) begin
        if (!mPending) chk(1'b0, "R7", "unexpected rspValid", 32'd1, 32'd0);
        else begin
          chk(mCyc == mExpWait, mTag, "latency", mCyc, mExpWait);
          chk(rspData == mExpData, "R7", "rspData", rspData, mExpData);
          mPending = 1'b0; mIdle = 0;
        end
      end else if (mPending && mCyc > mExpWait) begin
        chk(1'b0, mTag, "missing rspValid", mCyc, mExpWait);
        mPending = 1'b0;
      end
      chk(flashCeN == !mOpen, "R8", "flashCeN", flashCeN, !mOpen);
      chk(flashOeN == flashCeN, "R10", "flashOeN", flashOeN, flashCeN);
      chk(reqReady == !mPending, "R7", "reqReady", reqReady, !mPending);
      if (mOpen) begin
        chk(flashAddr == mWord, "R2", "flashAddr", flashAddr, mWord);
        chk(flashLane == mLane, "R2", "flashLane", flashLane, mLane);
        chk(flashByteN == !mMode, "R2", "flashByteN", flashByteN, !mMode);
      end
    end
    sV = reqValid; sR = reqReady; sAddr = reqAddr; sMode = reqByteMode;
  end

  function automatic logic [AW:0] mkAddr(input logic [AW-1:0] w, input logic ln,
                                         input logic m);
    return m ? {w, ln} : {ln, w};  // word mode: top bit is junk, must be ignored
  endfunction

  task automatic doRead(input logic [AW-1:0] w, input logic ln, input logic m,
                        input int gap);
    bit rdy;
    @(posedge clk); #1;
    repeat (gap) begin @(posedge clk); #1; end
    reqAddr = mkAddr(w, ln, m);
    reqByteMode = m;
    reqValid = 1'b1;
    do begin
      @(negedge clk); rdy = reqReady;
      @(posedge clk); #1;
    end while (!rdy);
    reqValid = 1'b0;
    reqAddr = {$urandom} [AW:0];
    wait (mPending);
    wait (!mPending);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [AW-1:0] w;
    logic ln, m;
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(flashCeN && flashOeN && flashByteN, "R1", "pins in reset",
        {flashCeN, flashOeN, flashByteN}, 3'b111);
    chk(reqReady && !rspValid, "R1", "handshake in reset", {reqReady, rspValid}, 2'b10);
    @(posedge clk); #1 rstN = 1'b1;
    @(negedge clk);
    chk(flashCeN && !rspValid, "R1", "after reset", {flashCeN, rspValid}, 2'b10);

    doRead(20'h12345, 1'b0, 1'b0, 0);          // R3 first access
    doRead(20'h12345, 1'b1, 1'b0, 0);          // R6 same word, junk top bit
    doRead(20'h12342, 1'b0, 1'b0, 1);          // R5 in page
    doRead(20'h54320, 1'b0, 1'b0, 0);          // R4 new page
    doRead(20'h54327, 1'b0, 1'b0, IL-2);       // R9 collides with expiry
    doRead(20'h54321, 1'b0, 1'b0, IL-1);       // R8 standby then full wait
    doRead(20'h54321, 1'b1, 1'b1, 0);          // R4 mode change, lane 1
    doRead(20'h54321, 1'b0, 1'b1, 0);          // R5 other lane same page
    doRead(20'h54321, 1'b0, 1'b1, 2);          // R6 same byte
    doRead(20'h54321, 1'b0, 1'b0, 0);          // R4 back to word mode

    w = 20'h0ABC8; ln = 1'b0; m = 1'b0;
    for (int i = 0; i < 400; i++) begin
      int r, g;
      r = int'($urandom % 100);
      if (r < 15) begin end
      else if (r < 55) begin w[2:0] = 3'($urandom); ln = m & 1'($urandom); end
      else if (r < 75) w = AW'($urandom);
      else if (r < 85) begin m = !m; ln = m & 1'($urandom); end
      else w = w + 20'd8;
      g = int'($urandom % 4);
      if (($urandom % 12) == 0) g = IL - 3 + int'($urandom % 4);
      doRead(w, ln, m, g);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule